// File: doc/BRIEF.md
# I2C Read Master

This block is the master side of a two-wire serial bus, and it only runs read transfers. Software loads a 7-bit target address and issues a command strobe. The command carries a begin flag and an end flag. On a begin command the block puts a start condition on the bus. It then sends the address with the direction bit set to read and checks that the target acknowledges. After that it clocks in data bytes. Each received byte is placed in a holding register, and a ready flag tells software a byte is waiting.

Software sets the length of a transfer by when it issues the end command. An end flag given in the same command as the begin flag makes a one-byte read. An end command given after a byte has been received makes the following byte the last one. The master refuses that last byte (it leaves SDA released on the ninth pulse) and then puts a stop condition on the bus. If the target does not acknowledge its address, the master stops at once and raises an address-refused flag.

Both bus lines are open-drain. The block drives each one only as a pull-low enable, and it reads the SDA level back through a synchronizer. Each SCL low phase and each SCL high phase lasts a programmable number of system clocks.

Top module: `i2c_rd_master`

## Requirements
- R1: A begin command accepted while idle produces a start condition (SDA pulled low while SCL is released), followed by the 7-bit address sent most significant bit first, one bit per SCL pulse.
- R2: The eighth bit of the address frame is the direction bit, sent as 1 (SDA released), which means read.
- R3: If SDA is high when sampled on the ninth pulse of the address frame, the block sets `addr_nack`, clocks no data byte, generates a stop condition and raises `xfer_done`.
- R4: On the ninth pulse of every data byte except the last, the master pulls SDA low (acknowledge). On the ninth pulse of the last byte it leaves SDA released, and then it generates a stop condition.
- R5: When the eighth bit of a data byte has been sampled, `rx_ready` goes high and `rx_byte` holds the byte, with the first received bit in bit 7. A one-cycle `rx_pop` pulse clears `rx_ready` at the next clock edge. `rx_byte` changes only when a new byte is loaded.
- R6: A command with both the begin and end flags set reads exactly one byte.
- R7: An end command issued after byte k has been flagged in `rx_ready`, and before byte k+1 starts clocking, makes byte k+1 the last byte of the transfer.
- R8: `xfer_done` is 1 after reset. It goes to 0 on the clock edge that accepts a begin command, and it returns to 1 once the stop condition has finished. While `xfer_done` is 1, both `scl_pull` and `sda_pull` are 0. An accepted begin command clears `addr_nack`.
- R9: During a transfer, every SCL low phase and every SCL high phase lasts exactly max(`half_period`, 2) clock cycles.
- R10: While SCL stays released, SDA changes only as a fall inside the start condition or as a rise inside the stop condition.
- R11: A begin command issued while a transfer is running is ignored, and the running transfer completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_start | input | 1 | Begin flag of the command: open a read transfer |
| cmd_stop | input | 1 | End flag of the command: the next byte to start is the last |
| slave_addr | input | 7 | Target address, captured when a begin command is accepted |
| half_period | input | DIV_W | SCL phase length in clocks (values below 2 count as 2) |
| rx_pop | input | 1 | Read strobe for the holding register; clears `rx_ready` |
| rx_byte | output | 8 | Holding register with the last received byte |
| rx_ready | output | 1 | A byte is waiting in the holding register |
| addr_nack | output | 1 | The target did not acknowledge its address |
| xfer_done | output | 1 | No transfer is running |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level of the SDA wire |

## Verification
The bound checker checks these rules on every cycle: SDA moves under a released SCL only inside the start and stop phases, the bus lines are released whenever the block is idle, `xfer_done` falls after an accepted begin command and rises only from the stop phase, an address refusal always leads straight into the stop phase, and the holding register sets, clears and holds its value as specified. Some behaviour can only be seen from whole transfers, so the bench shows it with a modelled target on the bus. This covers the address and direction bits as the target receives them, the acknowledge pattern across bytes of different lengths, how the timing of the end command sets the byte count, that a begin command during a transfer is ignored, and the measured SCL phase lengths for several divider settings, including the clamped values.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   localparam int unsigned ADDR_BITS  = 7;
   localparam int unsigned BYTE_BITS  = 8;
   localparam int unsigned FRAME_BITS = BYTE_BITS + 1;
   localparam logic        DIR_READ   = 1'b1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_START,
      ST_LOW,
      ST_HIGH,
      ST_STOP_LOW,
      ST_STOP_HIGH,
      ST_STOP_REL
   } bus_state_e;
endpackage

// File: rtl/i2cr_half_timer.sv
module i2cr_half_timer #(
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned MIN_HALF = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] cfg_div,
   output logic             tick
);
   localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_HALF);

   logic [DIV_W-1:0] half_len;
   logic [DIV_W-1:0] cnt;

   generate
      if (MIN_HALF > 1) begin : g_clamp
         assign half_len = (cfg_div < MIN_V) ? MIN_V : cfg_div;
      end else begin : g_raw
         assign half_len = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
      end
   endgenerate

   assign tick = run && (cnt == (half_len - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/i2cr_in_sync.sv
module i2cr_in_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe <= '1;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) begin
                  pipe[i] <= pipe[i-1];
               end
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2cr_shreg.sv
module i2cr_shreg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         sin,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= load_val;
      end else if (shift) begin
         q <= {q[W-2:0], sin};
      end
   end
endmodule

// File: rtl/i2cr_rx_hold.sv
module i2cr_rx_hold #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         ready
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout  <= '0;
         ready <= 1'b0;
      end else if (load) begin
         dout  <= din;
         ready <= 1'b1;
      end else if (pop) begin
         ready <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_rd_master.sv
module i2c_rd_master
   import i2cr_pkg::*;
#(
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned MIN_HALF    = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic                 cmd_start,
   input  logic                 cmd_stop,
   input  logic [ADDR_BITS-1:0] slave_addr,
   input  logic [DIV_W-1:0]     half_period,
   input  logic                 rx_pop,
   output logic [BYTE_BITS-1:0] rx_byte,
   output logic                 rx_ready,
   output logic                 addr_nack,
   output logic                 xfer_done,
   output logic                 scl_pull,
   output logic                 sda_pull,
   input  logic                 sda_in
);
   localparam int unsigned BIT_W = $clog2(FRAME_BITS);
   localparam logic [BIT_W-1:0] ACK_SLOT  = BIT_W'(BYTE_BITS);
   localparam logic [BIT_W-1:0] LAST_DBIT = BIT_W'(BYTE_BITS - 1);

   generate
      if (MIN_HALF < 2) begin : g_bad_min
         $error("MIN_HALF must be at least 2");
      end
      if (MIN_HALF >= (2 ** DIV_W)) begin : g_bad_div
         $error("MIN_HALF does not fit in DIV_W bits");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4 is not supported");
      end
      if (ADDR_BITS + 1 != BYTE_BITS) begin : g_bad_frame
         $error("address frame must fill one byte");
      end
   endgenerate

   bus_state_e           st, st_n;
   logic [BIT_W-1:0]     bit_idx;
   logic                 addr_phase;
   logic                 last_byte;
   logic                 stop_req;
   logic                 done_q;
   logic                 nack_q;
   logic                 scl_q;
   logic                 sda_q;
   logic [ADDR_BITS-1:0] addr_q;
   logic                 tick;
   logic                 sda_s;
   logic                 run;
   logic                 start_go;
   logic                 frame_end;
   logic                 sh_load;
   logic                 sh_shift;
   logic [BYTE_BITS-1:0] sh_q;
   logic                 rx_load;
   logic [BYTE_BITS-1:0] rx_din;

   assign run       = (st != ST_IDLE);
   assign start_go  = cmd_valid && cmd_start && (st == ST_IDLE);
   assign frame_end = (bit_idx == ACK_SLOT);
   assign sh_load   = (st == ST_START) && tick;
   assign sh_shift  = (st == ST_HIGH) && tick && !frame_end;
   assign rx_load   = (st == ST_HIGH) && tick && !addr_phase && (bit_idx == LAST_DBIT);
   assign rx_din    = {sh_q[BYTE_BITS-2:0], sda_s};

   i2cr_half_timer #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .cfg_div(half_period),
      .tick   (tick)
   );

   i2cr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (sda_in),
      .q    (sda_s)
   );

   i2cr_shreg #(.W(BYTE_BITS)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sh_load),
      .load_val({addr_q, DIR_READ}),
      .shift   (sh_shift),
      .sin     (sda_s),
      .q       (sh_q)
   );

   i2cr_rx_hold #(.W(BYTE_BITS)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (rx_load),
      .din  (rx_din),
      .pop  (rx_pop),
      .dout (rx_byte),
      .ready(rx_ready)
   );

   // Phase sequencing: every bus phase lasts one timer period.
   always_comb begin
      st_n = st;
      case (st)
         ST_IDLE:      if (start_go) st_n = ST_SETUP;
         ST_SETUP:     if (tick) st_n = ST_START;
         ST_START:     if (tick) st_n = ST_LOW;
         ST_LOW:       if (tick) st_n = ST_HIGH;
         ST_HIGH: begin
            if (tick) begin
               if (frame_end && (addr_phase ? sda_s : last_byte)) begin
                  st_n = ST_STOP_LOW;
               end else begin
                  st_n = ST_LOW;
               end
            end
         end
         ST_STOP_LOW:  if (tick) st_n = ST_STOP_HIGH;
         ST_STOP_HIGH: if (tick) st_n = ST_STOP_REL;
         ST_STOP_REL:  if (tick) st_n = ST_IDLE;
         default:      st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         bit_idx    <= '0;
         addr_phase <= 1'b1;
         last_byte  <= 1'b0;
         stop_req   <= 1'b0;
         done_q     <= 1'b1;
         nack_q     <= 1'b0;
         scl_q      <= 1'b0;
         sda_q      <= 1'b0;
         addr_q     <= '0;
      end else begin
         st    <= st_n;
         scl_q <= (st_n == ST_LOW) || (st_n == ST_STOP_LOW);

         if (start_go) begin
            done_q     <= 1'b0;
            nack_q     <= 1'b0;
            stop_req   <= cmd_stop;
            addr_q     <= slave_addr;
            addr_phase <= 1'b1;
            bit_idx    <= '0;
         end else if (cmd_valid && cmd_stop && run) begin
            stop_req <= 1'b1;
         end

         // SDA moves one clock into a phase, never on an SCL edge.
         case (st)
            ST_SETUP: sda_q <= 1'b0;
            ST_START: sda_q <= 1'b1;
            ST_LOW: begin
               if (frame_end) begin
                  sda_q <= !addr_phase && !last_byte;
               end else begin
                  sda_q <= addr_phase && !sh_q[BYTE_BITS-1];
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  if (!frame_end) begin
                     bit_idx <= bit_idx + 1'b1;
                  end else begin
                     bit_idx    <= '0;
                     addr_phase <= 1'b0;
                     last_byte  <= stop_req;
                     if (addr_phase && sda_s) begin
                        nack_q <= 1'b1;
                     end
                  end
               end
            end
            ST_STOP_LOW, ST_STOP_HIGH: sda_q <= 1'b1;
            ST_STOP_REL: begin
               sda_q <= 1'b0;
               if (tick) begin
                  done_q   <= 1'b1;
                  stop_req <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   assign scl_pull  = scl_q;
   assign sda_pull  = sda_q;
   assign xfer_done = done_q;
   assign addr_nack = nack_q;
endmodule

// File: rtl/i2c_rd_master_chk.sv
module i2c_rd_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_start,
   input logic       rx_pop,
   input logic       rx_load,
   input logic       rx_ready,
   input logic [7:0] rx_byte,
   input logic       addr_nack,
   input logic       xfer_done,
   input logic       scl_pull,
   input logic       sda_pull,
   input logic       in_start,
   input logic       in_stop
);
   // R10: an SDA fall under a released SCL happens only in the start phase
   p_sda_fall_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_pull && !$past(scl_pull) && $rose(sda_pull)) |-> in_start);

   // R10: an SDA rise under a released SCL happens only in the stop phase
   p_sda_rise_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_pull && !$past(scl_pull) && $fell(sda_pull)) |-> in_stop);

   // R8: an accepted begin command drops the done flag
   p_done_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_start && xfer_done) |=> !xfer_done);

   // R8: the bus is released whenever the block is idle
   p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (!scl_pull && !sda_pull));

   // R4: done rises only out of the stop phase
   p_done_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_done) |-> $past(in_stop));

   // R3: a refused address leads straight into the stop phase
   p_nack_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_nack) |-> (scl_pull && !xfer_done));

   // R5: a loaded byte raises ready
   p_load_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_load |=> rx_ready);

   // R5: a pop without a new byte clears ready
   p_pop_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && !rx_load) |=> !rx_ready);

   // R5: the holding register keeps its value between loads
   p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_load |=> $stable(rx_byte));
endmodule

bind i2c_rd_master i2c_rd_master_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_start(cmd_start),
   .rx_pop   (rx_pop),
   .rx_load  (rx_load),
   .rx_ready (rx_ready),
   .rx_byte  (rx_byte),
   .addr_nack(addr_nack),
   .xfer_done(xfer_done),
   .scl_pull (scl_pull),
   .sda_pull (sda_pull),
   .in_start (st == i2cr_pkg::ST_START),
   .in_stop  (st == i2cr_pkg::ST_STOP_REL)
);

// File: tb/i2c_rd_master_bench.sv
module i2c_rd_master_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_start = 1'b0;
   logic       cmd_stop = 1'b0;
   logic [6:0] slave_addr = '0;
   logic [7:0] half_period = 8'd2;
   logic       rx_pop = 1'b0;
   logic [7:0] rx_byte;
   logic       rx_ready;
   logic       addr_nack;
   logic       xfer_done;
   logic       scl_pull;
   logic       sda_pull;
   logic       sda_bus;
   logic       scl_bus;

   int total = 0;
   int bad = 0;
   int xtag = 0;
   int exp_half = 2;
   logic [6:0] slv_addr = 7'h52;

   always #10 clk = ~clk;  // 50 MHz

   i2c_rd_master u_i2c_rd_master (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_start  (cmd_start),
      .cmd_stop   (cmd_stop),
      .slave_addr (slave_addr),
      .half_period(half_period),
      .rx_pop     (rx_pop),
      .rx_byte    (rx_byte),
      .rx_ready   (rx_ready),
      .addr_nack  (addr_nack),
      .xfer_done  (xfer_done),
      .scl_pull   (scl_pull),
      .sda_pull   (sda_pull),
      .sda_in     (sda_bus)
   );

   function automatic logic [7:0] pattern(input int tag, input int k);
      logic [31:0] v;
      v = (tag * 29) + (k * 71) + 13;
      return v[7:0] ^ 8'(k << 3);
   endfunction

   function automatic logic pbit(input int tag, input int k, input int i);
      logic [7:0] b;
      b = pattern(tag, k);
      return b[7 - i];
   endfunction

   // ---------------- modelled target on the bus ----------------
   logic sl_pull = 1'b0;
   logic scl_d = 1'b1, sda_d = 1'b1;
   logic quiet = 1'b1;
   int   bi = 0, fi = 0;
   logic [7:0] sh = '0;
   logic [6:0] obs_addr = '0;
   logic obs_rw = 1'b0;
   int s_starts = 0, s_stops = 0, s_bytes = 0, s_acks = 0, s_nacks = 0;

   assign scl_bus = !scl_pull;
   assign sda_bus = !(sda_pull || sl_pull);

   always @(posedge clk) begin
      scl_d <= scl_bus;
      sda_d <= sda_bus;
      if (scl_bus && scl_d && sda_d && !sda_bus) begin
         s_starts <= s_starts + 1;
         bi <= 0; fi <= 0; quiet <= 1'b0; sl_pull <= 1'b0;
      end else if (scl_bus && scl_d && !sda_d && sda_bus) begin
         s_stops <= s_stops + 1;
         quiet <= 1'b1; sl_pull <= 1'b0;
      end else if (scl_d && !scl_bus) begin
         if (quiet) begin
            sl_pull <= 1'b0;
         end else if (fi == 0) begin
            if (bi == 8) begin
               obs_addr <= sh[7:1];
               obs_rw   <= sh[0];
               sl_pull  <= (sh[7:1] == slv_addr);
               if (sh[7:1] != slv_addr) quiet <= 1'b1;
            end else begin
               sl_pull <= 1'b0;
            end
         end else if (bi == 8) begin
            sl_pull <= 1'b0;
         end else begin
            sl_pull <= !pbit(xtag, fi - 1, bi);
         end
      end else if (!scl_d && scl_bus) begin
         sh <= {sh[6:0], sda_bus};
         if (fi != 0 && bi == 8 && !quiet) begin
            s_bytes <= s_bytes + 1;
            if (!sda_bus) s_acks <= s_acks + 1;
            else begin
               s_nacks <= s_nacks + 1;
               quiet <= 1'b1;
            end
         end
         if (bi == 8) begin bi <= 0; fi <= fi + 1; end
         else bi <= bi + 1;
      end
   end

   // ---------------- SCL phase length monitor (R9) ----------------
   logic mon_lvl = 1'b0;
   int   mon_len = 0;
   logic mon_seen_low = 1'b0;
   int   tmg_bad = 0;

   always @(negedge clk) begin
      if (xfer_done) mon_seen_low <= 1'b0;
      if (scl_pull == mon_lvl) begin
         mon_len <= mon_len + 1;
      end else begin
         if (!xfer_done) begin
            if (mon_lvl) begin
               if (mon_len != exp_half) tmg_bad <= tmg_bad + 1;
               mon_seen_low <= 1'b1;
            end else if (mon_seen_low && mon_len != exp_half) begin
               tmg_bad <= tmg_bad + 1;
            end
         end
         mon_lvl <= scl_pull;
         mon_len <= 1;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_done();
      int w = 0;
      while (!xfer_done && w < 20000) begin @(negedge clk); w++; end
   endtask

   task automatic run_xfer(input logic [6:0] a, input int n, input int cfg, input bit mid);
      bit hit;
      int b0, a0, n0, p0, s0, t0;
      hit = (a == slv_addr);
      half_period = 8'(cfg);
      exp_half = (cfg < 2) ? 2 : cfg;
      xtag++;
      @(negedge clk);
      b0 = s_bytes; a0 = s_acks; n0 = s_nacks; p0 = s_stops; s0 = s_starts; t0 = tmg_bad;
      slave_addr = a; cmd_valid = 1'b1; cmd_start = 1'b1; cmd_stop = (n == 1);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0;
      chk(!xfer_done, "R8 done low after accepted START", int'(xfer_done), 0);
      chk(!addr_nack, "R8 nack cleared by START", int'(addr_nack), 0);
      if (!hit) begin
         wait_done();
         chk(addr_nack, "R3 refused address sets nack", int'(addr_nack), 1);
         chk(xfer_done, "R3 done after refusal", int'(xfer_done), 1);
         chk(s_bytes - b0 == 0, "R3 no data clocked", s_bytes - b0, 0);
         chk(s_stops - p0 == 1, "R3 stop after refusal", s_stops - p0, 1);
         chk(obs_addr == a, "R1 address seen by target", int'(obs_addr), int'(a));
      end else begin
         for (int k = 0; k < n; k++) begin
            int w = 0;
            while (!rx_ready && w < 20000) begin @(negedge clk); w++; end
            chk(rx_byte == pattern(xtag, k), "R5 received byte", int'(rx_byte), int'(pattern(xtag, k)));
            rx_pop = 1'b1;
            if (k == n - 2) begin cmd_valid = 1'b1; cmd_stop = 1'b1; end
            if (mid && k == 0) begin cmd_valid = 1'b1; cmd_start = 1'b1; end
            @(negedge clk);
            rx_pop = 1'b0; cmd_valid = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0;
            chk(!rx_ready, "R5 pop clears ready", int'(rx_ready), 0);
         end
         wait_done();
         chk(xfer_done && !addr_nack, "R4 clean finish", int'(addr_nack), 0);
         if (n == 1) chk(s_bytes - b0 == 1, "R6 single byte read", s_bytes - b0, 1);
         else        chk(s_bytes - b0 == n, "R7 stop timing sets length", s_bytes - b0, n);
         chk(s_acks - a0 == n - 1, "R4 acks before last", s_acks - a0, n - 1);
         chk(s_nacks - n0 == 1, "R4 last byte refused", s_nacks - n0, 1);
         chk(s_stops - p0 == 1, "R4 stop after last", s_stops - p0, 1);
         chk(s_starts - s0 == 1, "R1 one start condition", s_starts - s0, 1);
         chk(obs_addr == a, "R1 address MSB first", int'(obs_addr), int'(a));
         chk(obs_rw == 1'b1, "R2 direction bit read", int'(obs_rw), 1);
         if (mid) chk(s_bytes - b0 == n && s_starts - s0 == 1, "R11 START ignored while busy", s_bytes - b0, n);
      end
      chk(tmg_bad == t0, "R9 SCL phase length", tmg_bad - t0, 0);
      chk(!scl_pull && !sda_pull, "R8 bus released when done", int'({scl_pull, sda_pull}), 0);
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd4242);
      slv_addr = 7'h52;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(xfer_done, "R8 reset done", int'(xfer_done), 1);
      chk(!rx_ready, "R5 reset ready", int'(rx_ready), 0);
      chk(!addr_nack, "R8 reset nack", int'(addr_nack), 0);
      chk(!scl_pull && !sda_pull, "R8 reset bus released", int'({scl_pull, sda_pull}), 0);

      run_xfer(slv_addr, 1, 0, 1'b0);              // R6, clamp of 0
      run_xfer(slv_addr ^ 7'h01, 3, 3, 1'b0);      // R3
      run_xfer(slv_addr, 2, 1, 1'b0);              // R7, clamp of 1
      run_xfer(slv_addr, 4, 4, 1'b1);              // R11
      run_xfer(7'h7f & ~slv_addr, 1, 2, 1'b0);     // R3 with single-byte command

      for (int i = 0; i < 10; i++) begin
         int n, cfg;
         bit miss, mid;
         n    = 1 + int'($urandom % 5);
         cfg  = int'($urandom % 7);
         miss = (($urandom % 5) == 0);
         mid  = (n >= 3) && (($urandom % 2) == 1);
         run_xfer(miss ? (slv_addr ^ 7'h10) : slv_addr, n, cfg, mid);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
   end
endmodule